// File: doc/BRIEF.md
# Configuration Unlock Guard

This block guards a handful of sensitive I/O registers on a simple CPU I/O bus. Software must first write a fixed key value to a dedicated key register. That write opens a short unlock window, measured in instruction cycles. While the window is open, writes to the guarded registers produce write enables, and the interrupt request to the CPU is held low. At all other times, writes to the guarded registers are dropped without effect.

The window is driven by a two-state machine with the states LOCKED and OPEN. The transitions are:

- UNLOCK: LOCKED to OPEN, on a key write that carries the key value.
- RESTART: OPEN to OPEN, on another key write with the key value. This reloads the count.
- ABORT: OPEN to LOCKED, on a key write with any other value.
- EXPIRE: OPEN to LOCKED, when the last instruction-cycle strobe of the window is seen.
- RESET: any state to LOCKED, on the synchronous reset.

A down-counter loaded on UNLOCK and on RESTART measures the window. It moves only on the instruction-cycle strobe, so bus wait states lengthen the window in clock cycles but not in instructions.

Top module: `cfg_unlock_guard`

## Requirements
- R1: The key register sits at I/O address 0x3C and is 8 bits wide. After reset, a read of it returns 0x00 and the window is closed.
- R2: A write of the value 0xD8 to the key register opens the window from the next clock cycle.
- R3: The window stays open through exactly four instruction-cycle strobes that follow the key write. The cycle that carries the fourth strobe is still open, and the next cycle is closed. A strobe in the same cycle as the key write does not count. Cycles without a strobe do not shorten the window.
- R4: Outside the window, a write to a guarded register raises no write enable.
- R5: Inside the window, a write to guarded register i raises `prot_we[i]` in that same cycle, and the window stays open. Bit 0 is clock select (0x36), bit 1 is the clock prescaler (0x37) and bit 2 is watchdog control (0x31).
- R6: A read of the key register returns the window state in bit 0, with bits 7:1 at zero. The written value is never stored. A read of any other address returns 0x00.
- R7: A key write of any value other than 0xD8 leaves a closed window closed and closes an open window from the next cycle.
- R8: A key write of 0xD8 while the window is open restarts the count of four strobes.
- R9: `irq_out` is 0 while the window is open and follows `irq_in` while it is closed. A request that is held through the window is delivered in the first closed cycle.
- R10: A synchronous reset closes an open window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 6 | I/O bus address |
| io_wdata | input | 8 | I/O bus write data |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| insn_stb | input | 1 | One pulse per completed instruction cycle |
| irq_in | input | 1 | Raw interrupt request |
| io_rdata | output | 8 | Read data, combinational |
| prot_we | output | 3 | Write enables for the guarded registers |
| irq_out | output | 1 | Interrupt request after gating |

## Verification
The hardest case to reach is a key write that lands while the window is already open. Depending on the value written, it must either restart the count or abort the window. The stimulus opens a window and spends two strobes. It then writes the key again in a cycle that also carries a strobe, and reads the key register on every following cycle to find exactly where the window closes. Wait-state stretching is reached the same way, by holding the strobe low for many cycles in the middle of a window.

// File: rtl/cfg_unlock_pkg.sv
package cfg_unlock_pkg;

    // Window states
    typedef enum logic [0:0] {
        ST_LOCKED = 1'b0,
        ST_OPEN   = 1'b1
    } win_state_t;

    // Key value that opens the window
    localparam logic [7:0] UNLOCK_KEY = 8'hD8;

endpackage

// File: rtl/cfg_unlock_decode.sv
module cfg_unlock_decode #(
    parameter int                        ADDR_W     = 6,
    parameter int                        DATA_W     = 8,
    parameter int                        N_PROT     = 3,
    parameter logic [ADDR_W-1:0]         KEY_ADDR   = 6'h3C,
    parameter logic [N_PROT*ADDR_W-1:0]  PROT_ADDRS = {6'h31, 6'h37, 6'h36},
    parameter logic [DATA_W-1:0]         KEY_VALUE  = 8'hD8
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_wr,
    output logic              key_hit,
    output logic              key_wr,
    output logic              key_ok,
    output logic [N_PROT-1:0] prot_hit
);

    always_comb begin
        key_hit = (io_addr == KEY_ADDR);
        key_wr  = io_wr && key_hit;
        key_ok  = (io_wdata == KEY_VALUE);
    end

    // One address comparator for each guarded register
    for (genvar gi = 0; gi < N_PROT; gi++) begin : g_prot
        assign prot_hit[gi] = (io_addr == PROT_ADDRS[gi*ADDR_W +: ADDR_W]);
    end

endmodule

// File: rtl/cfg_unlock_window.sv
module cfg_unlock_window
    import cfg_unlock_pkg::*;
#(
    parameter int WIN_CYCLES = 4,
    localparam int CNT_W     = $clog2(WIN_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic key_wr,
    input  logic key_ok,
    input  logic insn_stb,
    output logic win_open
);

    localparam logic [CNT_W-1:0] WIN_LOAD = CNT_W'(WIN_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    win_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_LOCKED: begin
                if (key_wr && key_ok) begin        // UNLOCK
                    state_d = ST_OPEN;
                    cnt_d   = WIN_LOAD;
                end
            end
            ST_OPEN: begin
                if (key_wr) begin
                    if (key_ok) begin              // RESTART
                        cnt_d = WIN_LOAD;
                    end else begin                 // ABORT
                        state_d = ST_LOCKED;
                        cnt_d   = '0;
                    end
                end else if (insn_stb) begin
                    if (cnt_q == CNT_LAST) begin   // EXPIRE
                        state_d = ST_LOCKED;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - CNT_LAST;
                    end
                end
            end
            default: begin
                state_d = ST_LOCKED;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin                             // RESET
            state_q <= ST_LOCKED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            ST_OPEN:   win_open = 1'b1;
            ST_LOCKED: win_open = 1'b0;
            default:   win_open = 1'b0;
        endcase
    end

    AST_KEY_OPENS: assert property (@(posedge clk) disable iff (rst)
        (key_wr && key_ok) |=> (win_open && cnt_q == WIN_LOAD)); // R2
    AST_BAD_KEY_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (key_wr && !key_ok) |=> !win_open); // R7
    AST_NO_STB_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (win_open && !insn_stb && !key_wr) |=> (win_open && $stable(cnt_q))); // R3
    AST_OPEN_CNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
        win_open |-> (cnt_q != '0)); // R3

endmodule

// File: rtl/cfg_unlock_gate.sv
module cfg_unlock_gate #(
    parameter int DATA_W = 8,
    parameter int N_PROT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              win_open,
    input  logic              key_hit,
    input  logic [N_PROT-1:0] prot_hit,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic              irq_in,
    output logic [N_PROT-1:0] prot_we,
    output logic              irq_out,
    output logic [DATA_W-1:0] io_rdata
);

    always_comb begin
        prot_we  = (io_wr && win_open) ? prot_hit : '0;
        irq_out  = irq_in && !win_open;
        io_rdata = (io_rd && key_hit) ? {{(DATA_W-1){1'b0}}, win_open} : '0;
    end

    AST_LOCKED_NO_WE: assert property (@(posedge clk) disable iff (rst)
        !win_open |-> (prot_we == '0)); // R4
    AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(prot_we)); // R5
    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
        win_open |-> !irq_out); // R9
    AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        io_rdata[DATA_W-1:1] == '0); // R6

endmodule

// File: rtl/cfg_unlock_guard.sv
module cfg_unlock_guard #(
    parameter int                        ADDR_W     = 6,
    parameter int                        DATA_W     = 8,
    parameter int                        N_PROT     = 3,
    parameter int                        WIN_CYCLES = 4,
    parameter logic [ADDR_W-1:0]         KEY_ADDR   = 6'h3C,
    parameter logic [N_PROT*ADDR_W-1:0]  PROT_ADDRS = {6'h31, 6'h37, 6'h36},
    parameter logic [DATA_W-1:0]         KEY_VALUE  = cfg_unlock_pkg::UNLOCK_KEY
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic              insn_stb,
    input  logic              irq_in,
    output logic [DATA_W-1:0] io_rdata,
    output logic [N_PROT-1:0] prot_we,
    output logic              irq_out
);

    logic              key_hit;
    logic              key_wr;
    logic              key_ok;
    logic [N_PROT-1:0] prot_hit;
    logic              win_open;

    cfg_unlock_decode #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .N_PROT     (N_PROT),
        .KEY_ADDR   (KEY_ADDR),
        .PROT_ADDRS (PROT_ADDRS),
        .KEY_VALUE  (KEY_VALUE)
    ) u_decode (
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .io_wr    (io_wr),
        .key_hit  (key_hit),
        .key_wr   (key_wr),
        .key_ok   (key_ok),
        .prot_hit (prot_hit)
    );

    cfg_unlock_window #(
        .WIN_CYCLES (WIN_CYCLES)
    ) u_window (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (key_wr),
        .key_ok   (key_ok),
        .insn_stb (insn_stb),
        .win_open (win_open)
    );

    cfg_unlock_gate #(
        .DATA_W (DATA_W),
        .N_PROT (N_PROT)
    ) u_gate (
        .clk      (clk),
        .rst      (rst),
        .win_open (win_open),
        .key_hit  (key_hit),
        .prot_hit (prot_hit),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .irq_in   (irq_in),
        .prot_we  (prot_we),
        .irq_out  (irq_out),
        .io_rdata (io_rdata)
    );

endmodule

// File: tb/cfg_unlock_guard_bench.sv
module cfg_unlock_guard_bench;

    localparam int         CLK_PERIOD = 10;
    localparam logic [5:0] A_KEY  = 6'h3C;
    localparam logic [5:0] A_CSEL = 6'h36;
    localparam logic [5:0] A_CDIV = 6'h37;
    localparam logic [5:0] A_WDOG = 6'h31;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] io_addr = '0;
    logic [7:0] io_wdata = '0;
    logic       io_wr = 1'b0;
    logic       io_rd = 1'b0;
    logic       insn_stb = 1'b0;
    logic       irq_in = 1'b0;
    logic [7:0] io_rdata;
    logic [2:0] prot_we;
    logic       irq_out;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_unlock_guard u_cfg_unlock_guard (
        .clk      (clk),
        .rst      (rst),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .insn_stb (insn_stb),
        .irq_in   (irq_in),
        .io_rdata (io_rdata),
        .prot_we  (prot_we),
        .irq_out  (irq_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive the bus at a falling edge and let the combinational outputs settle
    task automatic bus(input logic [5:0] a, input logic [7:0] d,
                       input logic wr, input logic rd, input logic stb);
        io_addr  = a;
        io_wdata = d;
        io_wr    = wr;
        io_rd    = rd;
        insn_stb = stb;
        #1;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic read_key(input logic stb, input string req, input logic [7:0] exp);
        bus(A_KEY, 8'h00, 1'b0, 1'b1, stb);
        check(req, io_rdata, exp);
        tick();
    endtask

    task automatic write_key(input logic [7:0] v, input logic stb);
        bus(A_KEY, v, 1'b1, 1'b0, stb);
        tick();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        bus('0, '0, 1'b0, 1'b0, 1'b0);
        tick();
        tick();
        rst = 1'b0;
        tick();
    endtask

    task automatic t_reset_state();
        read_key(1'b0, "R1 reset read", 8'h00);
        bus(A_CSEL, 8'hAA, 1'b1, 1'b0, 1'b0);
        check("R1 reset no we", {5'b0, prot_we}, 8'h00);
        tick();
    endtask

    task automatic t_window_length();
        write_key(8'hD8, 1'b1);                    // R2: strobe in key cycle does not count
        for (int i = 0; i < 4; i++) read_key(1'b1, "R3 open strobe", 8'h01);
        read_key(1'b0, "R3 closed after 4", 8'h00);
    endtask

    task automatic t_stretch();
        write_key(8'hD8, 1'b0);
        read_key(1'b1, "R3 stretch s1", 8'h01);
        for (int i = 0; i < 10; i++) read_key(1'b0, "R3 no strobe", 8'h01);
        for (int i = 0; i < 3; i++) read_key(1'b1, "R3 stretch tail", 8'h01);
        read_key(1'b0, "R3 stretch closed", 8'h00);
    endtask

    task automatic t_locked_writes();
        bus(A_CSEL, 8'h11, 1'b1, 1'b0, 1'b1);
        check("R4 locked csel", {5'b0, prot_we}, 8'h00);
        tick();
        bus(A_CDIV, 8'h22, 1'b1, 1'b0, 1'b1);
        check("R4 locked cdiv", {5'b0, prot_we}, 8'h00);
        tick();
        bus(A_WDOG, 8'h33, 1'b1, 1'b0, 1'b1);
        check("R4 locked wdog", {5'b0, prot_we}, 8'h00);
        tick();
    endtask

    task automatic t_window_writes();
        write_key(8'hD8, 1'b0);
        bus(A_CSEL, 8'h01, 1'b1, 1'b0, 1'b1);
        check("R5 we csel", {5'b0, prot_we}, 8'h01);
        tick();
        bus(A_CDIV, 8'h02, 1'b1, 1'b0, 1'b1);
        check("R5 we cdiv", {5'b0, prot_we}, 8'h02);
        tick();
        read_key(1'b0, "R5 still open", 8'h01);
        bus(A_WDOG, 8'h03, 1'b1, 1'b0, 1'b1);
        check("R5 we wdog", {5'b0, prot_we}, 8'h04);
        tick();
        bus(A_WDOG, 8'h04, 1'b1, 1'b0, 1'b1);     // fourth strobe, still open
        check("R5 we last slot", {5'b0, prot_we}, 8'h04);
        tick();
        bus(A_WDOG, 8'h05, 1'b1, 1'b0, 1'b0);
        check("R4 we after close", {5'b0, prot_we}, 8'h00);
        tick();
    endtask

    task automatic t_readback();
        write_key(8'hFF, 1'b0);
        read_key(1'b0, "R6 value not stored", 8'h00);
        write_key(8'hD8, 1'b0);
        bus(A_CSEL, 8'h00, 1'b0, 1'b1, 1'b0);
        check("R6 other addr reads 0", io_rdata, 8'h00);
        tick();
        read_key(1'b0, "R6 open bit only", 8'h01);
        write_key(8'h00, 1'b0);
    endtask

    task automatic t_bad_key();
        write_key(8'h55, 1'b1);
        read_key(1'b0, "R7 bad key closed", 8'h00);
        write_key(8'hD8, 1'b0);
        read_key(1'b1, "R7 open before abort", 8'h01);
        write_key(8'hD9, 1'b0);
        read_key(1'b0, "R7 abort", 8'h00);
    endtask

    task automatic t_restart();
        write_key(8'hD8, 1'b0);
        read_key(1'b1, "R8 pre s1", 8'h01);
        read_key(1'b1, "R8 pre s2", 8'h01);
        write_key(8'hD8, 1'b1);
        for (int i = 0; i < 4; i++) read_key(1'b1, "R8 restarted", 8'h01);
        read_key(1'b0, "R8 closed", 8'h00);
    endtask

    task automatic t_irq();
        irq_in = 1'b1;
        bus('0, '0, 1'b0, 1'b0, 1'b0);
        check("R9 pass closed", {7'b0, irq_out}, 8'h01);
        bus(A_KEY, 8'hD8, 1'b1, 1'b0, 1'b0);
        check("R9 key cycle pass", {7'b0, irq_out}, 8'h01);
        tick();
        for (int i = 0; i < 4; i++) begin
            bus('0, '0, 1'b0, 1'b0, 1'b1);
            check("R9 masked", {7'b0, irq_out}, 8'h00);
            tick();
        end
        bus('0, '0, 1'b0, 1'b0, 1'b0);
        check("R9 delivered", {7'b0, irq_out}, 8'h01);
        irq_in = 1'b0;
        #1;
        check("R9 follows low", {7'b0, irq_out}, 8'h00);
        tick();
    endtask

    task automatic t_reset_mid();
        write_key(8'hD8, 1'b0);
        read_key(1'b1, "R10 open", 8'h01);
        rst = 1'b1;
        bus('0, '0, 1'b0, 1'b0, 1'b0);
        tick();
        rst = 1'b0;
        read_key(1'b0, "R10 closed by reset", 8'h00);
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_window_length();
        t_stretch();
        t_locked_writes();
        t_window_writes();
        t_readback();
        t_bad_key();
        t_restart();
        t_irq();
        t_reset_mid();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule